// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes command bytes written over a simple synchronous write strobe and runs the program and erase operations of a small NOR-style flash array held inside it. The array holds 32 blocks of a few bytes each, and every block has its own lock bit. A master write-protect switch decides whether those lock bits are enforced. The controller models execution time with cycle counters. A write keeps it busy for a short time and an erase for a longer one. An erase can be paused so that the array can be read, and then resumed.

A host writes a command byte, then an address and data byte or a confirm byte where the command needs one. It then watches the ready/busy output or reads the status byte. The read port is combinational. It returns array contents, the status byte or a fixed device code, depending on which read mode the last command selected. Error flags in the status byte stay set until the host clears them.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, readyBusy is 1, the read mode is array, every array byte reads FFH, and the status byte reads 80H.
- R2: Command 40H or 10H, followed by one write that carries the target address and data, programs that byte to the bitwise AND of its old value and the data. readyBusy is low for exactly WRITE_CYCLES cycles and the read mode becomes status.
- R3: Command 20H, followed by D0H at any address inside a block, sets every byte of that block to FFH after ERASE_CYCLES busy cycles. Other blocks are left unchanged, and the erase clears that block's lock bit.
- R4: Command A7H, followed by D0H, erases every block except those that are locked while write-protect is active, and clears the lock bits of the blocks it erases.
- R5: B0H written while an erase is running suspends it. readyBusy returns to 1, status bit 6 is set and the array reads its pre-erase contents. D0H resumes the erase, which then completes. B0H written while no erase is running changes nothing.
- R6: Status byte layout: bit 7 is ready, bit 6 is suspended, bit 5 is the erase error, bit 4 is the write error, bit 3 is low VPP, and bits 2 to 0 read 0. If vppOk is low in the data or confirm cycle, the operation does not run and bit 3 is set, together with bit 4 for a write or bit 5 for an erase.
- R7: Bits 5 to 3 stay set until command 50H clears them. A write or erase whose data or confirm cycle arrives while any of them is set does not run, and it sets bits 4 and 5.
- R8: Command 77H, followed by D0H at an address inside a block, locks that block. While write-protect is active, a write to a locked block sets bit 4 and an erase of it sets bit 5. In both cases the array is left unchanged.
- R9: Write-protect is active after reset. Command 57H makes it active. Command 47H followed by D0H releases it, and while it is released, locked blocks can be written and erased.
- R10: Command 90H makes every address read 21H. FFH returns the read port to array mode.
- R11: An unrecognised command byte, or a byte other than D0H where a confirm is expected, sets bits 4 and 5 and selects array read mode.
- R12: While a write or erase runs unsuspended, every command byte except B0H and 70H is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one bus cycle |
| addr | input | ADDR_W (7) | Byte address for writes and reads; the upper bits select the block |
| wrData | input | 8 | Command, confirm or program data byte |
| vppOk | input | 1 | Programming supply is valid |
| rdData | output | 8 | Array byte, status byte or device code, depending on read mode |
| readyBusy | output | 1 | 1 when ready or suspended, 0 while an operation executes |

## Verification
A vector table first programs bytes with values that overlap, so that an AND result can be told apart from a plain overwrite. It then erases one block while the neighbouring bytes hold data, to show that the erase stays within its block. Directed sequences then replay the same write and erase under several conditions: low VPP, sticky flags still set, a locked block with protect on and with protect off, a wrong confirm byte, and command bytes written while busy. Each of these has its own expected status byte, so the failure causes can be told apart. Suspend is tested by reading the array mid-erase and then again after the resume completes. A chip erase with one locked block shows which blocks it skips.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_STATUS     = 8'h70;
  localparam logic [7:0] CMD_CLEAR      = 8'h50;
  localparam logic [7:0] CMD_PROG_A     = 8'h40;
  localparam logic [7:0] CMD_PROG_B     = 8'h10;
  localparam logic [7:0] CMD_ERASE_BLK  = 8'h20;
  localparam logic [7:0] CMD_ERASE_ALL  = 8'hA7;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_PROT_ON    = 8'h57;
  localparam logic [7:0] CMD_PROT_OFF   = 8'h47;
  localparam logic [7:0] CMD_LOCK_BLK   = 8'h77;
  localparam logic [7:0] DEVICE_CODE    = 8'h21;

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_ERB, S_ERC, S_LOCK, S_UNPROT} ctrlState_t;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_ID} readMode_t;
  typedef enum logic [1:0] {OP_WRITE, OP_ERB, OP_ERC} opKind_t;

  typedef struct packed {
    logic latchTgt;
    logic commitWrite;
    logic commitEraseBlk;
    logic commitEraseChip;
    logic setLock;
    logic protect;
  } dpStrobe_t;
endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int WRITE_CYCLES = 4,
  parameter int ERASE_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       vppOk,
  input  logic       lockHit,
  output dpStrobe_t  strobes,
  output readMode_t  readMode,
  output logic [7:0] statusByte,
  output logic       readyBusy
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ERASE_CYCLES - 1);

  ctrlState_t       state;
  opKind_t          kind;
  logic             running, susp, wpActive;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       errBits;   // [2]=erase err, [1]=write err, [0]=low vpp

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      readMode <= RM_ARRAY;
      kind     <= OP_WRITE;
      running  <= 1'b0;
      susp     <= 1'b0;
      wpActive <= 1'b1;
      cnt      <= '0;
      errBits  <= '0;
    end else begin
      if (running && !susp) begin
        if (cnt == '0) running <= 1'b0;
        else           cnt     <= cnt - 1'b1;
      end
      if (wrEn) begin
        if (running && !susp) begin
          if (wrData == CMD_SUSPEND && kind != OP_WRITE && cnt != '0) begin
            susp     <= 1'b1;
            readMode <= RM_STATUS;
          end else if (wrData == CMD_STATUS) begin
            readMode <= RM_STATUS;
          end
        end else if (running) begin
          case (wrData)
            CMD_READ_ARRAY: readMode <= RM_ARRAY;
            CMD_STATUS:     readMode <= RM_STATUS;
            CMD_READ_ID:    readMode <= RM_ID;
            CMD_CONFIRM: begin susp <= 1'b0; readMode <= RM_STATUS; end
            default: ;
          endcase
        end else begin
          state    <= S_IDLE;
          readMode <= RM_STATUS;
          case (state)
            S_IDLE: begin
              case (wrData)
                CMD_READ_ARRAY: readMode <= RM_ARRAY;
                CMD_READ_ID:    readMode <= RM_ID;
                CMD_STATUS, CMD_SUSPEND: ;
                CMD_CLEAR:      errBits <= '0;
                CMD_PROG_A, CMD_PROG_B: state <= S_PROG;
                CMD_ERASE_BLK:  state <= S_ERB;
                CMD_ERASE_ALL:  state <= S_ERC;
                CMD_LOCK_BLK:   state <= S_LOCK;
                CMD_PROT_OFF:   state <= S_UNPROT;
                CMD_PROT_ON:    wpActive <= 1'b1;
                default: begin errBits[2:1] <= 2'b11; readMode <= RM_ARRAY; end
              endcase
            end
            S_PROG: begin
              if (errBits != '0)          errBits[2:1] <= 2'b11;
              else if (!vppOk)            errBits[1:0] <= 2'b11;
              else if (wpActive && lockHit) errBits[1] <= 1'b1;
              else begin running <= 1'b1; kind <= OP_WRITE; cnt <= WR_LOAD; end
            end
            default: begin
              if (wrData != CMD_CONFIRM) begin
                errBits[2:1] <= 2'b11;
                readMode     <= RM_ARRAY;
              end else if (state == S_UNPROT) begin
                wpActive <= 1'b0;
              end else if (state == S_ERB || state == S_ERC) begin
                if (errBits != '0) errBits[2:1] <= 2'b11;
                else if (!vppOk) begin errBits[2] <= 1'b1; errBits[0] <= 1'b1; end
                else if (state == S_ERB && wpActive && lockHit) errBits[2] <= 1'b1;
                else begin
                  running <= 1'b1;
                  kind    <= (state == S_ERB) ? OP_ERB : OP_ERC;
                  cnt     <= ER_LOAD;
                end
              end
            end
          endcase
        end
      end
    end
  end

  logic finishing;
  assign finishing = running && !susp && cnt == '0;

  always_comb begin
    strobes.latchTgt        = wrEn && !running;
    strobes.commitWrite     = finishing && kind == OP_WRITE;
    strobes.commitEraseBlk  = finishing && kind == OP_ERB;
    strobes.commitEraseChip = finishing && kind == OP_ERC;
    strobes.setLock         = wrEn && !running && state == S_LOCK && wrData == CMD_CONFIRM;
    strobes.protect         = wpActive;
  end

  assign readyBusy  = !(running && !susp);
  assign statusByte = {readyBusy, susp, errBits, 3'b000};
endmodule

// File: rtl/flash_datapath.sv
module flash_datapath
  import flash_pkg::*;
#(
  parameter int NUM_BLOCKS      = 32,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int ADDR_W          = $clog2(NUM_BLOCKS * WORDS_PER_BLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  dpStrobe_t         strobes,
  output logic              lockHit,
  output logic [7:0]        arrayData
);
  localparam int NUM_WORDS = NUM_BLOCKS * WORDS_PER_BLOCK;
  localparam int OFF_W     = $clog2(WORDS_PER_BLOCK);
  localparam int BLK_W     = ADDR_W - OFF_W;

  logic [7:0]            mem [NUM_WORDS];
  logic [NUM_BLOCKS-1:0] lockBits;
  logic [ADDR_W-1:0]     tgtAddr;
  logic [7:0]            tgtData;
  logic [BLK_W-1:0]      tgtBlk, liveBlk;

  assign tgtBlk    = tgtAddr[ADDR_W-1:OFF_W];
  assign liveBlk   = addr[ADDR_W-1:OFF_W];
  assign lockHit   = lockBits[liveBlk];
  assign arrayData = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgtAddr <= '0;
      tgtData <= '0;
    end else if (strobes.latchTgt) begin
      tgtAddr <= addr;
      tgtData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (strobes.commitWrite && ADDR_W'(i) == tgtAddr)
          mem[i] <= mem[i] & tgtData;
        if (strobes.commitEraseBlk && BLK_W'(i >> OFF_W) == tgtBlk)
          mem[i] <= 8'hFF;
        if (strobes.commitEraseChip && !(strobes.protect && lockBits[i >> OFF_W]))
          mem[i] <= 8'hFF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockBits <= '0;
    end else begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        if (strobes.setLock && BLK_W'(b) == liveBlk) lockBits[b] <= 1'b1;
        if (strobes.commitEraseBlk && BLK_W'(b) == tgtBlk) lockBits[b] <= 1'b0;
        if (strobes.commitEraseChip && !strobes.protect) lockBits[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int NUM_BLOCKS      = 32,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int WRITE_CYCLES    = 4,
  parameter int ERASE_CYCLES    = 40,
  parameter int ADDR_W          = $clog2(NUM_BLOCKS * WORDS_PER_BLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              vppOk,
  output logic [7:0]        rdData,
  output logic              readyBusy
);
  dpStrobe_t  ctlStb;
  readMode_t  readMode;
  logic [7:0] statusByte, arrayData;
  logic       lockHit;

  flash_ctrl #(.WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .vppOk(vppOk),
    .lockHit(lockHit), .strobes(ctlStb), .readMode(readMode),
    .statusByte(statusByte), .readyBusy(readyBusy)
  );

  flash_datapath #(.NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
                   .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrData(wrData), .strobes(ctlStb),
    .lockHit(lockHit), .arrayData(arrayData)
  );

  always_comb begin
    case (readMode)
      RM_STATUS: rdData = statusByte;
      RM_ID:     rdData = DEVICE_CODE;
      default:   rdData = arrayData;
    endcase
  end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       readyBusy,
  input logic [7:0] statusByte,
  input logic       wpActive
);
  // R2: busy only begins in response to a bus write (start or resume)
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(readyBusy) |-> $past(wrEn));
  // R7: each sticky flag only drops after a clear-status command
  p_sticky_vpp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(statusByte[3]) |-> $past(wrEn && wrData == 8'h50));
  p_sticky_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(statusByte[4]) |-> $past(wrEn && wrData == 8'h50));
  p_sticky_er_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(statusByte[5]) |-> $past(wrEn && wrData == 8'h50));
  // R5: suspension is entered only through the suspend command
  p_suspend_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusByte[6]) |-> $past(wrEn && wrData == 8'hB0));
  // R6: a suspended operation reports ready
  p_suspend_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    statusByte[6] |-> readyBusy);
  // R6: low status bits always read zero
  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    statusByte[2:0] == 3'b000);
  // R9: protect is released only by a confirm byte
  p_unprotect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wpActive) |-> $past(wrEn && wrData == 8'hD0));
endmodule

bind flash_cmd_ctrl flash_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .readyBusy(readyBusy),
  .statusByte(statusByte), .wpActive(ctlStb.protect)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WR_CYC = 4;
  localparam int ER_CYC = 40;

  logic       clk = 0, rst_n = 0, wrEn = 0, vppOk = 1;
  logic [6:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       readyBusy;
  int         nChecks = 0, nFails = 0;
  bit         finished = 0;

  flash_cmd_ctrl #(.WRITE_CYCLES(WR_CYC), .ERASE_CYCLES(ER_CYC)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .vppOk(vppOk), .rdData(rdData), .readyBusy(readyBusy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wcyc(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input string req, input logic [6:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdData, exp);
  endtask

  task automatic waitReady(input string req);
    int n = 0;
    while (!readyBusy && n < 1000) begin @(negedge clk); n++; end
    chk(req, {7'd0, readyBusy}, 8'd1);
  endtask

  typedef struct packed {
    logic [1:0] op;   // 0 write cycle, 1 read check, 2 wait ready
    logic [3:0] req;
    logic [6:0] a;
    logic [7:0] d;
  } vec_t;
  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd1,  7'd5,  8'hFF},  // R1 array after reset
    '{2'd0, 4'd1,  7'd0,  8'h70},
    '{2'd1, 4'd1,  7'd0,  8'h80},  // R1 status after reset
    '{2'd0, 4'd2,  7'd0,  8'h40},  // R2 program F0 at 5
    '{2'd0, 4'd2,  7'd5,  8'hF0},
    '{2'd2, 4'd2,  7'd0,  8'h00},
    '{2'd1, 4'd2,  7'd0,  8'h80},
    '{2'd0, 4'd2,  7'd0,  8'hFF},
    '{2'd1, 4'd2,  7'd5,  8'hF0},
    '{2'd0, 4'd2,  7'd0,  8'h10},  // R2 AND with 3C
    '{2'd0, 4'd2,  7'd5,  8'h3C},
    '{2'd2, 4'd2,  7'd0,  8'h00},
    '{2'd0, 4'd2,  7'd0,  8'hFF},
    '{2'd1, 4'd2,  7'd5,  8'h30},
    '{2'd0, 4'd2,  7'd0,  8'h40},  // R2 program 0A at 12
    '{2'd0, 4'd2,  7'd12, 8'h0A},
    '{2'd2, 4'd2,  7'd0,  8'h00},
    '{2'd0, 4'd10, 7'd0,  8'h90},  // R10 device code
    '{2'd1, 4'd10, 7'd0,  8'h21},
    '{2'd1, 4'd10, 7'd9,  8'h21},
    '{2'd0, 4'd10, 7'd0,  8'hFF},
    '{2'd1, 4'd10, 7'd12, 8'h0A},
    '{2'd0, 4'd3,  7'd0,  8'h20},  // R3 erase block 1
    '{2'd0, 4'd3,  7'd6,  8'hD0},
    '{2'd2, 4'd3,  7'd0,  8'h00},
    '{2'd0, 4'd3,  7'd0,  8'hFF},
    '{2'd1, 4'd3,  7'd5,  8'hFF},
    '{2'd1, 4'd3,  7'd12, 8'h0A}   // R3 neighbour block untouched
  };

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int busyCnt;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", {7'd0, readyBusy}, 8'd1);
    rst_n = 1;
    chk("R1 ready out of reset", {7'd0, readyBusy}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        2'd0: wcyc(VECS[i].a, VECS[i].d);
        2'd1: rd(tag, VECS[i].a, VECS[i].d);
        default: waitReady(tag);
      endcase
    end

    // R2: busy window length
    wcyc(0, 8'h40); wcyc(7'd1, 8'h7F);
    busyCnt = 0;
    while (!readyBusy && busyCnt < 100) begin busyCnt++; @(negedge clk); end
    chk("R2 busy cycles", 8'(busyCnt), 8'(WR_CYC));

    // R5 + R12: suspend/resume; ignored commands while busy
    wcyc(0, 8'h40); wcyc(7'd8, 8'h55); waitReady("R5 prep");
    wcyc(0, 8'h20); wcyc(7'd8, 8'hD0);
    chk("R3 busy during erase", {7'd0, readyBusy}, 8'd0);
    wcyc(0, 8'h40); wcyc(7'd13, 8'h00);   // R12 ignored while busy
    wcyc(0, 8'hB0);
    chk("R5 ready when suspended", {7'd0, readyBusy}, 8'd1);
    rd("R5 status suspended", 0, 8'hC0);
    wcyc(0, 8'hFF);
    rd("R5 array readable in suspend", 7'd8, 8'h55);
    wcyc(0, 8'hD0);
    chk("R5 busy after resume", {7'd0, readyBusy}, 8'd0);
    waitReady("R5 resume completes");
    wcyc(0, 8'hFF);
    rd("R5 erase finished", 7'd8, 8'hFF);
    rd("R12 write during busy ignored", 7'd13, 8'hFF);
    wcyc(0, 8'hB0);
    rd("R5 suspend with no erase ignored", 0, 8'h80);

    // R6 + R7: low VPP, sticky retry, clear
    vppOk = 0;
    wcyc(0, 8'h40); wcyc(7'd14, 8'h00);
    chk("R6 no busy on low vpp", {7'd0, readyBusy}, 8'd1);
    rd("R6 low vpp status", 0, 8'h98);
    vppOk = 1;
    wcyc(0, 8'h40); wcyc(7'd14, 8'h00);
    rd("R7 retry while sticky", 0, 8'hB8);
    wcyc(0, 8'hFF);
    rd("R7 array unchanged", 7'd14, 8'hFF);
    wcyc(0, 8'h50);
    rd("R7 cleared", 0, 8'h80);
    wcyc(0, 8'h40); wcyc(7'd14, 8'h00); waitReady("R7 retry after clear");
    wcyc(0, 8'hFF);
    rd("R7 retry written", 7'd14, 8'h00);

    // R8 + R9: lock and protect
    wcyc(0, 8'h77); wcyc(7'd16, 8'hD0);
    rd("R8 lock status", 0, 8'h80);
    wcyc(0, 8'h40); wcyc(7'd16, 8'h00);
    rd("R8 locked write error", 0, 8'h90);
    wcyc(0, 8'hFF);
    rd("R8 locked write no change", 7'd16, 8'hFF);
    wcyc(0, 8'h50);
    wcyc(0, 8'h20); wcyc(7'd17, 8'hD0);
    rd("R8 locked erase error", 0, 8'hA0);
    wcyc(0, 8'h50);
    wcyc(0, 8'h47); wcyc(0, 8'hD0);
    wcyc(0, 8'h40); wcyc(7'd16, 8'h0F); waitReady("R9 write unprotected");
    wcyc(0, 8'hFF);
    rd("R9 locked block written when protect off", 7'd16, 8'h0F);
    wcyc(0, 8'h20); wcyc(7'd16, 8'hD0); waitReady("R3 erase locked block");
    wcyc(0, 8'h57);
    wcyc(0, 8'h40); wcyc(7'd16, 8'hAA); waitReady("R3 lock cleared by erase");
    rd("R3 no error after erase cleared lock", 0, 8'h80);
    wcyc(0, 8'hFF);
    rd("R3 write after erase", 7'd16, 8'hAA);

    // R11: unknown command, wrong confirm
    wcyc(0, 8'h33);
    rd("R11 unknown selects array", 7'd16, 8'hAA);
    wcyc(0, 8'h70);
    rd("R11 unknown sets 4 and 5", 0, 8'hB0);
    wcyc(0, 8'h50);
    wcyc(0, 8'h20); wcyc(7'd16, 8'h11);
    rd("R11 wrong confirm array", 7'd16, 8'hAA);
    wcyc(0, 8'h70);
    rd("R11 wrong confirm status", 0, 8'hB0);
    wcyc(0, 8'h50);

    // R4: chip erase skips locked block under protect
    wcyc(0, 8'h40); wcyc(7'd20, 8'h00); waitReady("R4 prep");
    wcyc(0, 8'h77); wcyc(7'd20, 8'hD0);
    wcyc(0, 8'hA7); wcyc(0, 8'hD0);
    chk("R4 busy", {7'd0, readyBusy}, 8'd0);
    waitReady("R4 done");
    wcyc(0, 8'hFF);
    rd("R4 erased", 7'd16, 8'hFF);
    rd("R4 erased other", 7'd12, 8'hFF);
    rd("R4 locked kept", 7'd20, 8'h00);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule